// File: doc/BRIEF.md
# Framed Circular Receive Buffer Reader

This block drains a receive ring buffer on the consumer side. A producer elsewhere stores words into a memory region and moves a write index forward. The reader owns only the read index. Each frame in the ring starts with one header word, which carries a byte count, a framing-mode code, a voice/silence flag and an end-of-frame flag. The reader fetches that header and decodes it. It then fetches the payload words one at a time and hands the low byte of each to a downstream consumer over a valid/ready byte stream. Every beat carries the frame's attributes.

The ring is described by a base address, a length in words and the producer's write index. Every access to index `len-1` is followed by index 0, so the address goes back to the base. The reader only starts a frame when the ring holds unread words. Mid-frame, it waits whenever the next word to fetch sits at the write index. The working read index is private until the whole frame has been handed off. Then the reader publishes it on `rptr` with a one-cycle `rptr_upd` strobe.

States: `ST_IDLE` (ring empty) → `ST_HDR_REQ` (header read issued) → `ST_HDR_CAP` (header decoded). From `ST_HDR_CAP`, a zero length goes to `ST_BEAT` with a marker and a non-zero length goes to `ST_DAT_REQ`. `ST_DAT_REQ` waits at the write index, then issues a read and moves to `ST_DAT_CAP` (byte captured) → `ST_BEAT` (beat offered). From `ST_BEAT`, an accepted beat goes to `ST_DAT_REQ` if bytes remain, or to `ST_COMMIT` if none remain. `ST_COMMIT` publishes the pointer and returns to `ST_IDLE`.

Top module: `frb_reader`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `mem_rd_en` and `rptr_upd` are 0 and `rptr` is 0.
- R2: While the published read index equals `prod_wptr` and no frame is in progress, `mem_rd_en` stays 0.
- R3: A frame's header is read from address `cfg_base + rptr`. Header bits [8:0] are the payload byte count, and bits [15:13] are ignored.
- R4: Each beat carries the header's mode bits [10:9] on `out_mode` (00 async start/stop, 01 raw bitstream, 10 HDLC, 11 async with multiple stop bits), bit 11 on `out_voice` (1 voice, 0 silence) and bit 12 on `out_eof`.
- R5: A frame with count N > 0 yields exactly N beats with `out_empty` = 0. Beat k carries bits [7:0] of the k-th word after the header, and the upper eight bits of each payload word are ignored.
- R6: Read accesses follow the index sequence 0,1,…,`cfg_len`-1,0,… at address `cfg_base` + index, and never leave that window.
- R7: No word is read at the index equal to `prod_wptr`. A frame stalls at that point without emitting further beats or a pointer update, and it resumes when `prod_wptr` moves on.
- R8: A header with count 0 consumes one word and yields a single beat with `out_empty` = 1 and `out_data` = 0.
- R9: `out_last` is 1 only on the final beat of a frame (the single marker for a zero-length frame) and only when that frame's end-of-frame bit is 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and every beat field holds its value.
- R11: `rptr` changes only together with a one-cycle `rptr_upd` pulse, once per frame after its last beat is accepted. The new value is the index just past the frame's last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_len | input | IDX_W | Ring length in words (non-zero) |
| prod_wptr | input | IDX_W | Producer write index |
| mem_rd_en | output | 1 | Memory read strobe; data returns next cycle |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 16 | Memory read data, one cycle after the strobe |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Beat accepted when high with `out_valid` |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final beat of a frame with end-of-frame set |
| out_empty | output | 1 | Beat is a zero-length frame marker |
| out_mode | output | 2 | Framing mode of the current frame |
| out_voice | output | 1 | Voice (1) or silence (0) frame |
| out_eof | output | 1 | End-of-frame bit of the current frame |
| rptr | output | IDX_W | Published read index |
| rptr_upd | output | 1 | One-cycle strobe when `rptr` is published |

## Verification
A working index that drifts by one word appears at the ports almost at once. The next read address leaves the expected wrap sequence within a cycle, and the next beat carries a payload byte that belongs to a neighbour. A header latched wrongly shows up on the first beat of that frame as a wrong mode, flag or beat count, and a lost remaining-byte count shows up as a missing or extra last beat. A commit taken at the wrong moment shows up in the same cycle as an `rptr_upd` strobe with a value that does not match the producer's frame boundary.

// File: rtl/frb_pkg.sv
package frb_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 9;
    localparam int MODE_LSB  = 9;
    localparam int VOICE_BIT = 11;
    localparam int EOF_BIT   = 12;
    localparam int HDR_TOP   = 12;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'b00,
        MODE_RAW      = 2'b01,
        MODE_HDLC     = 2'b10,
        MODE_ASYNC_MS = 2'b11
    } frb_mode_e;

    typedef struct packed {
        logic      eof;
        logic      voice;
        frb_mode_e mode;
    } frb_attr_t;

    typedef struct packed {
        frb_attr_t        attr;
        logic [LEN_W-1:0] len;
    } frb_hdr_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              empty;
        frb_attr_t         attr;
    } frb_beat_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HDR_REQ = 3'd1,
        ST_HDR_CAP = 3'd2,
        ST_DAT_REQ = 3'd3,
        ST_DAT_CAP = 3'd4,
        ST_BEAT    = 3'd5,
        ST_COMMIT  = 3'd6
    } frb_state_e;

endpackage

// File: rtl/frb_ctl_decode.sv
module frb_ctl_decode
    import frb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output frb_hdr_t          hdr
);

    logic [WORD_W-HDR_TOP-2:0] unused_hi;

    assign unused_hi       = word[WORD_W-1:HDR_TOP+1];
    assign hdr.len         = word[LEN_W-1:0];
    assign hdr.attr.mode   = frb_mode_e'(word[MODE_LSB+1:MODE_LSB]);
    assign hdr.attr.voice  = word[VOICE_BIT];
    assign hdr.attr.eof    = word[EOF_BIT];

endmodule

// File: rtl/frb_wrap_step.sv
module frb_wrap_step #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  len,
    input  logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  nxt,
    output logic [ADDR_W-1:0] addr
);

    logic [IDX_W-1:0] top_idx;

    assign top_idx = len - IDX_W'(1);
    assign nxt     = (idx == top_idx) ? '0 : idx + IDX_W'(1);

    generate
        if (ADDR_W > IDX_W) begin : g_widen
            assign addr = base + {{(ADDR_W-IDX_W){1'b0}}, idx};
        end else begin : g_narrow
            assign addr = base + idx[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/frb_out_hold.sv
module frb_out_hold
    import frb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  frb_beat_t ld_beat,
    input  logic      ready,
    output logic      valid,
    output logic      take,
    output frb_beat_t beat
);

    logic      valid_q;
    frb_beat_t beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            beat_q  <= ld_beat;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end

    assign take  = valid_q & ready;
    assign valid = valid_q;
    assign beat  = beat_q;

    // R10: an offered beat stays put until it is taken
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready) |=> (valid_q && $stable(beat_q)));

    // R10: a new beat is never loaded over one still waiting
    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid_q);

endmodule

// File: rtl/frb_reader.sv
module frb_reader
    import frb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_len,
    input  logic [IDX_W-1:0]  prod_wptr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [15:0]       mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              out_empty,
    output logic [1:0]        out_mode,
    output logic              out_voice,
    output logic              out_eof,
    output logic [IDX_W-1:0]  rptr,
    output logic              rptr_upd
);

    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

    frb_state_e        state_q, state_d;
    logic [IDX_W-1:0]  widx_q, widx_nxt, rptr_q;
    logic [ADDR_W-1:0] widx_addr;
    logic [LEN_W-1:0]  rem_q;
    frb_attr_t         attr_q;
    frb_hdr_t          hdr_dec;
    frb_beat_t         ld_beat, cur_beat;
    logic              has_word, ld, take, adv_idx, cap_hdr, cap_byte, commit;

    frb_wrap_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
        .idx  (widx_q),
        .len  (cfg_len),
        .base (cfg_base),
        .nxt  (widx_nxt),
        .addr (widx_addr)
    );

    frb_ctl_decode u_dec (
        .word (mem_rd_data),
        .hdr  (hdr_dec)
    );

    frb_out_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .ld_beat (ld_beat),
        .ready   (out_ready),
        .valid   (out_valid),
        .take    (take),
        .beat    (cur_beat)
    );

    assign has_word = (widx_q != prod_wptr);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (has_word) state_d = ST_HDR_REQ;
            ST_HDR_REQ: state_d = ST_HDR_CAP;
            ST_HDR_CAP: state_d = (hdr_dec.len == '0) ? ST_BEAT : ST_DAT_REQ;
            ST_DAT_REQ: if (has_word) state_d = ST_DAT_CAP;
            ST_DAT_CAP: state_d = ST_BEAT;
            ST_BEAT:    if (take) state_d = (rem_q == '0) ? ST_COMMIT : ST_DAT_REQ;
            ST_COMMIT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        mem_rd_en = 1'b0;
        ld        = 1'b0;
        ld_beat   = '0;
        cap_hdr   = 1'b0;
        cap_byte  = 1'b0;
        adv_idx   = 1'b0;
        commit    = 1'b0;
        rptr_upd  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HDR_REQ: mem_rd_en = 1'b1;
            ST_HDR_CAP: begin
                cap_hdr = 1'b1;
                adv_idx = 1'b1;
                if (hdr_dec.len == '0) begin
                    ld            = 1'b1;
                    ld_beat.empty = 1'b1;
                    ld_beat.last  = hdr_dec.attr.eof;
                    ld_beat.attr  = hdr_dec.attr;
                end
            end
            ST_DAT_REQ: mem_rd_en = has_word;
            ST_DAT_CAP: begin
                cap_byte     = 1'b1;
                adv_idx      = 1'b1;
                ld           = 1'b1;
                ld_beat.data = mem_rd_data[BYTE_W-1:0];
                ld_beat.last = attr_q.eof && (rem_q == ONE_LEFT);
                ld_beat.attr = attr_q;
            end
            ST_BEAT:   commit = take && (rem_q == '0);
            ST_COMMIT: rptr_upd = 1'b1;
            default: ;
        endcase
    end

    // working index, remaining count, frame attributes, published pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx_q <= '0;
            rptr_q <= '0;
            rem_q  <= '0;
            attr_q <= '0;
        end else begin
            if (adv_idx)  widx_q <= widx_nxt;
            if (cap_hdr) begin
                attr_q <= hdr_dec.attr;
                rem_q  <= hdr_dec.len;
            end
            if (cap_byte) rem_q  <= rem_q - ONE_LEFT;
            if (commit)   rptr_q <= widx_q;
        end
    end

    assign mem_rd_addr = widx_addr;
    assign rptr        = rptr_q;
    assign out_data    = cur_beat.data;
    assign out_last    = cur_beat.last;
    assign out_empty   = cur_beat.empty;
    assign out_mode    = cur_beat.attr.mode;
    assign out_voice   = cur_beat.attr.voice;
    assign out_eof     = cur_beat.attr.eof;

    // R11: the published pointer moves only with its strobe
    p_rptr_moves_with_upd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr != $past(rptr)) |-> rptr_upd);

    // R11: the strobe lasts a single cycle
    p_upd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_upd |=> !rptr_upd);

    // R6: every read stays inside the ring window
    p_rd_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((mem_rd_addr - cfg_base) < ADDR_W'(cfg_len)));

    // R7: no read at the producer's write index
    p_rd_not_at_wptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (widx_q != prod_wptr));

    // R9: a last beat only on frames flagged end-of-frame
    p_last_needs_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_eof);

    // R8: a marker carries no data and closes its frame per its eof bit
    p_marker_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_empty) |-> (out_data == '0 && out_last == out_eof));

endmodule

// File: tb/frb_reader_tb_top.sv
`timescale 1ns/1ps
module frb_reader_tb_top;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = 8;
    localparam int RLEN   = 24;
    localparam logic [ADDR_W-1:0] BASE = 12'h120;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  wptr = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [15:0]       mem_rd_data = '0;
    logic              out_valid, out_ready = 1'b0;
    logic [7:0]        out_data;
    logic              out_last, out_empty, out_voice, out_eof;
    logic [1:0]        out_mode;
    logic [IDX_W-1:0]  rptr;
    logic              rptr_upd;

    logic [15:0] mem [0:1023];
    logic [13:0] exp_q[$];
    logic [IDX_W-1:0] ptr_q[$];
    int checks = 0, fails = 0;
    int ridx = 0, pidx = 0, rd_cnt = 0, upd_cnt = 0, beat_cnt = 0;
    logic hold_pend = 1'b0;
    logic [13:0] hold_v = '0;
    logic [7:0] lfsr = 8'h5B;

    always #2.5 clk = ~clk;

    frb_reader #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_len(IDX_W'(RLEN)),
        .prod_wptr(wptr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_empty(out_empty),
        .out_mode(out_mode), .out_voice(out_voice), .out_eof(out_eof),
        .rptr(rptr), .rptr_upd(rptr_upd));

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

    function automatic int wrapn(input int i);
        return (i + 1 == RLEN) ? 0 : i + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] cur_beat();
        return {out_data, out_last, out_empty, out_mode, out_voice, out_eof};
    endfunction

    // ready pattern, driven away from the sampling edge
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[2];
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) begin
                rd_cnt++;
                chk(mem_rd_addr == BASE + ADDR_W'(ridx), "R3 R6 read address", 32'(mem_rd_addr), 32'(BASE + ADDR_W'(ridx)));
                ridx = wrapn(ridx);
            end
            if (hold_pend)
                chk(out_valid && cur_beat() == hold_v, "R10 beat held under backpressure", {17'd0, out_valid, cur_beat()}, {17'd0, 1'b1, hold_v});
            hold_pend = out_valid && !out_ready;
            hold_v    = cur_beat();
            if (out_valid && out_ready) begin
                beat_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected beat", 32'(cur_beat()), 32'h0);
                end else begin
                    logic [13:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e[13:6], "R5 payload byte", 32'(out_data), 32'(e[13:6]));
                    chk({out_mode, out_voice, out_eof} == e[3:0], "R4 beat attributes", 32'({out_mode, out_voice, out_eof}), 32'(e[3:0]));
                    chk(out_last == e[5], "R9 last flag", 32'(out_last), 32'(e[5]));
                    chk(out_empty == e[4], "R8 empty marker flag", 32'(out_empty), 32'(e[4]));
                end
            end
            if (rptr_upd) begin
                upd_cnt++;
                if (ptr_q.size() == 0) chk(1'b0, "R11 unexpected pointer update", 32'(rptr), 32'h0);
                else begin
                    logic [IDX_W-1:0] p;
                    p = ptr_q.pop_front();
                    chk(rptr == p, "R11 published read index", 32'(rptr), 32'(p));
                end
            end
        end
    end

    // write one frame into the ring and queue its expected beats
    task automatic put_frame(input bit eof, input bit voice, input logic [1:0] mode,
                             input int len, input logic [7:0] seed, input int expose);
        int idx;
        int hdr_idx;
        hdr_idx = pidx;
        idx = pidx;
        mem[10'(BASE + ADDR_W'(idx))] = {3'b101, eof, voice, mode, 9'(len)};
        idx = wrapn(idx);
        if (len == 0) exp_q.push_back({8'h00, eof, 1'b1, mode, voice, eof});
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 7);
            mem[10'(BASE + ADDR_W'(idx))] = {8'hC3 ^ 8'(i), b};
            exp_q.push_back({b, eof && (i == len - 1), 1'b0, mode, voice, eof});
            idx = wrapn(idx);
        end
        ptr_q.push_back(IDX_W'(idx));
        pidx = idx;
        if (expose < 0) wptr = IDX_W'(idx);
        else            wptr = IDX_W'((hdr_idx + expose) % RLEN);
    endtask

    task automatic wait_done();
        while (!(rptr == IDX_W'(pidx) && exp_q.size() == 0)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int snap_rd, snap_upd, snap_beat;
        for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(!out_valid, "R1 out_valid in reset", 32'(out_valid), 0);
        chk(!mem_rd_en, "R1 mem_rd_en in reset", 32'(mem_rd_en), 0);
        chk(!rptr_upd,  "R1 rptr_upd in reset", 32'(rptr_upd), 0);
        chk(rptr == '0, "R1 rptr in reset", 32'(rptr), 0);
        rst_n = 1'b1;
        // R2 empty ring: no reads
        repeat (12) @(negedge clk);
        chk(rd_cnt == 0, "R2 no read on empty ring", rd_cnt, 0);

        put_frame(1'b1, 1'b1, 2'b00, 3, 8'h10, -1); wait_done();
        put_frame(1'b0, 1'b0, 2'b10, 5, 8'h40, -1); wait_done();
        put_frame(1'b1, 1'b0, 2'b01, 0, 8'h00, -1); wait_done();   // R8 marker, last
        put_frame(1'b0, 1'b1, 2'b11, 0, 8'h00, -1); wait_done();   // R8 marker, not last
        put_frame(1'b1, 1'b1, 2'b11, 10, 8'h77, -1); wait_done();
        put_frame(1'b1, 1'b0, 2'b10, 8, 8'hA1, -1); wait_done();   // R6 wraps past ring end

        // R7 stall: expose header plus two bytes of a six-byte frame
        snap_upd  = upd_cnt;
        snap_beat = beat_cnt;
        put_frame(1'b1, 1'b1, 2'b01, 6, 8'h30, 3);
        repeat (40) @(negedge clk);
        snap_rd = rd_cnt;
        chk(beat_cnt - snap_beat == 2, "R7 beats before stall", beat_cnt - snap_beat, 2);
        chk(upd_cnt == snap_upd, "R7 no pointer update while stalled", upd_cnt, snap_upd);
        repeat (10) @(negedge clk);
        chk(rd_cnt == snap_rd, "R7 no read at write index", rd_cnt, snap_rd);
        wptr = IDX_W'(pidx);
        wait_done();

        put_frame(1'b1, 1'b0, 2'b00, 12, 8'h05, -1); wait_done();

        // R2 idle after draining
        snap_rd = rd_cnt;
        repeat (20) @(negedge clk);
        chk(rd_cnt == snap_rd, "R2 no read once drained", rd_cnt, snap_rd);
        chk(exp_q.size() == 0, "R5 all expected beats seen", exp_q.size(), 0);
        chk(ptr_q.size() == 0, "R11 one update per frame", ptr_q.size(), 0);
        chk(upd_cnt == 8, "R11 update count", upd_cnt, 8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=%0d exp=0", exp_q.size());
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule